// File: doc/BRIEF.md
# Multiplexed Sampling Timing Generator

This block produces every sampling strobe for a 16-channel multiplexed analog capture path. Its only timing input is one reference clock, which runs at four times the per-channel sample rate (1.280 MHz for a 320 kHz sample rate). It divides each sample period into four reference-clock slots. In fixed slots it issues three staggered one-cycle pulses: an advance pulse for the analog multiplexer, a convert pulse for the A/D converter, and an internal sample tick that clocks the downstream capture logic. The gap between the advance pulse and the tick leaves the analog path time to settle.

It also keeps a channel index that steps once per sample period. When the tick for the last channel of a sweep arrives, it raises a sweep strobe. A frame counter driven by complete sweeps opens a transmission window on every 200th sweep and holds it high for that whole sweep, so every channel of that sweep falls inside it. At the default rates the window opens at 100 Hz.

Top module: `samp_timing_gen`

## Requirements
- R1: While `rst` is high, and in the cycle it is sampled high, all pulse outputs, `sweep_done_o` and `tx_window_o` are low and `chan_idx_o` is 0.
- R2: A sample period is 4 clock cycles. Each period carries exactly one `mux_step_o`, one `adc_conv_o` and one `smp_tick_o`, and no two of these pulses are ever high in the same cycle.
- R3: Slot numbering starts at 0 in the first cycle after the first rising edge at which `rst` is low. `mux_step_o` is high in slot 0, `adc_conv_o` in slot 1 and `smp_tick_o` in slot 3. Slot 2 has no pulse.
- R4: `chan_idx_o` holds steady through a sample period and increases by one at the boundary after the period's `smp_tick_o`. The first period after reset shows channel 0.
- R5: `sweep_done_o` is high only together with the `smp_tick_o` of channel 15, which gives one strobe every 64 cycles. In the next cycle `chan_idx_o` is 0.
- R6: `tx_window_o` is high for exactly 64 consecutive cycles. It opens in slot 0 of channel 0 of every 200th sweep. The first window opens 12736 cycles after slot numbering starts (199 full sweeps), and the window repeats every 12800 cycles.
- R7: Each window contains exactly 16 `smp_tick_o` pulses and one `sweep_done_o`, and that strobe falls in the window's last cycle.
- R8: Asserting `rst` in the middle of a run returns all outputs to the R1 state. On release the slot, channel and frame counting restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, four cycles per sample period |
| rst | input | 1 | Synchronous active-high reset |
| mux_step_o | output | 1 | Multiplexer channel-advance pulse (slot 0) |
| adc_conv_o | output | 1 | Converter start/read pulse (slot 1) |
| smp_tick_o | output | 1 | Internal sample tick (slot 3) |
| chan_idx_o | output | 4 | Channel selected for the current sample period |
| sweep_done_o | output | 1 | High with the sample tick of the last channel |
| tx_window_o | output | 1 | Transmission-window enable, one full sweep long |

## Verification
On every cycle the assertions check that the three pulses are mutually exclusive and keep their slot spacing. They also check that the channel index holds or steps by one, that it wraps right after the sweep strobe, that the frame count moves only on sweep ends, and that each window opens on channel 0 and lasts exactly one sweep. Only the bench scenarios can show the absolute placement against reset release: the exact cycle of the first window, its 12800-cycle repeat, and the pulse and strobe counts inside a window. The same holds for the full restart after a reset in mid-run.

// File: rtl/samp_timing_pkg.sv
package samp_timing_pkg;

  localparam int PULSE_N = 3;
  localparam int P_MUX   = 0;
  localparam int P_ADC   = 1;
  localparam int P_SMP   = 2;

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // cycles from slot 'from' forward to slot 'to' inside a period of 'slots'
  function automatic int slot_gap(input int from, input int to, input int slots);
    return (to - from + slots) % slots;
  endfunction

  function automatic int sweep_cycles(input int slots, input int chans);
    return slots * chans;
  endfunction

  function automatic int window_open_cycle(input int slots, input int chans,
                                           input int frames);
    return (frames - 1) * slots * chans;
  endfunction

endpackage

// File: rtl/slot_phase.sv
module slot_phase
  import samp_timing_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int MUX_SLOT = 0,
  parameter int ADC_SLOT = 1,
  parameter int SMP_SLOT = 3
) (
  input  logic clk,
  input  logic rst,
  output logic run_o,
  output logic period_end_o,
  output logic mux_o,
  output logic adc_o,
  output logic smp_o
);
  localparam int SW = cnt_width(SLOTS);
  localparam int TGT [PULSE_N] = '{MUX_SLOT, ADC_SLOT, SMP_SLOT};
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  logic          run_q;
  logic [SW-1:0] slot_q;
  logic [PULSE_N-1:0] pulse_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end

  for (genvar g = 0; g < PULSE_N; g++) begin : g_pulse
    assign pulse_w[g] = run_q && (slot_q == SW'(TGT[g]));
  end

  assign run_o        = run_q;
  assign period_end_o = run_q && (slot_q == LAST_SLOT);
  assign mux_o        = pulse_w[P_MUX];
  assign adc_o        = pulse_w[P_ADC];
  assign smp_o        = pulse_w[P_SMP];

  // checker state: cycles elapsed since the last multiplexer pulse
  logic          seen_mux_q;
  logic [SW:0]   since_mux_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_mux_q  <= 1'b0;
      since_mux_q <= '0;
    end else if (mux_o) begin
      seen_mux_q  <= 1'b1;
      since_mux_q <= (SW+1)'(1);
    end else if (since_mux_q != '1) begin
      since_mux_q <= since_mux_q + 1'b1;
    end
  end

  p_pulses_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mux_o, adc_o, smp_o}));
  p_adc_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (adc_o && seen_mux_q) |-> (since_mux_q == (SW+1)'(slot_gap(MUX_SLOT, ADC_SLOT, SLOTS))));
  p_smp_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_o && seen_mux_q) |-> (since_mux_q == (SW+1)'(slot_gap(MUX_SLOT, SMP_SLOT, SLOTS))));
  p_period_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    period_end_o |=> !period_end_o);
endmodule

// File: rtl/channel_sweep.sv
module channel_sweep
  import samp_timing_pkg::*;
#(
  parameter int CHANNELS = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          adv_i,
  input  logic                          smp_i,
  output logic [cnt_width(CHANNELS)-1:0] chan_o,
  output logic                          sweep_o,
  output logic                          sweep_end_o
);
  localparam int CW = cnt_width(CHANNELS);
  localparam logic [CW-1:0] LAST_CH = CW'(CHANNELS - 1);

  logic [CW-1:0] chan_q;
  logic          at_last_w;

  assign at_last_w = (chan_q == LAST_CH);

  always_ff @(posedge clk) begin
    if (rst)        chan_q <= '0;
    else if (adv_i) chan_q <= at_last_w ? '0 : chan_q + 1'b1;
  end

  assign chan_o      = chan_q;
  assign sweep_o     = smp_i && at_last_w;
  assign sweep_end_o = adv_i && at_last_w;

  p_chan_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(chan_q));
  p_chan_step_r4: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !at_last_w) |=> (chan_q == CW'($past(chan_q) + 1'b1)));
  p_chan_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    sweep_end_o |=> (chan_q == '0));
endmodule

// File: rtl/window_gate.sv
module window_gate
  import samp_timing_pkg::*;
#(
  parameter int FRAMES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic sweep_end_i,
  output logic tx_o
);
  localparam int FW = cnt_width(FRAMES);
  localparam logic [FW-1:0] LAST_FR = FW'(FRAMES - 1);

  logic [FW-1:0] frm_q;

  always_ff @(posedge clk) begin
    if (rst)              frm_q <= '0;
    else if (sweep_end_i) frm_q <= (frm_q == LAST_FR) ? '0 : frm_q + 1'b1;
  end

  assign tx_o = run_i && (frm_q == LAST_FR);

  p_frame_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !sweep_end_i |=> $stable(frm_q));
  p_frame_bound_r6: assert property (@(posedge clk) disable iff (rst)
    frm_q <= LAST_FR);
endmodule

// File: rtl/samp_timing_gen.sv
module samp_timing_gen
  import samp_timing_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int CHANNELS = 16,
  parameter int FRAMES   = 200,
  parameter int MUX_SLOT = 0,
  parameter int ADC_SLOT = 1,
  parameter int SMP_SLOT = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic                          mux_step_o,
  output logic                          adc_conv_o,
  output logic                          smp_tick_o,
  output logic [cnt_width(CHANNELS)-1:0] chan_idx_o,
  output logic                          sweep_done_o,
  output logic                          tx_window_o
);
  localparam int WIN_LEN = sweep_cycles(SLOTS, CHANNELS);
  localparam int LW      = cnt_width(WIN_LEN + 1) + 1;

  logic run_w, period_end_w, sweep_end_w;

  slot_phase #(
    .SLOTS(SLOTS), .MUX_SLOT(MUX_SLOT), .ADC_SLOT(ADC_SLOT), .SMP_SLOT(SMP_SLOT)
  ) u_phase (
    .clk(clk), .rst(rst),
    .run_o(run_w), .period_end_o(period_end_w),
    .mux_o(mux_step_o), .adc_o(adc_conv_o), .smp_o(smp_tick_o)
  );

  channel_sweep #(.CHANNELS(CHANNELS)) u_sweep (
    .clk(clk), .rst(rst),
    .adv_i(period_end_w), .smp_i(smp_tick_o),
    .chan_o(chan_idx_o), .sweep_o(sweep_done_o), .sweep_end_o(sweep_end_w)
  );

  window_gate #(.FRAMES(FRAMES)) u_window (
    .clk(clk), .rst(rst), .run_i(run_w),
    .sweep_end_i(sweep_end_w), .tx_o(tx_window_o)
  );

  // checker state: length of the current transmission window
  logic [LW-1:0] win_len_q;
  always_ff @(posedge clk) begin
    if (rst)              win_len_q <= '0;
    else if (tx_window_o) win_len_q <= win_len_q + 1'b1;
    else                  win_len_q <= '0;
  end

  p_window_length_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_window_o) |-> (win_len_q == LW'(WIN_LEN)));
  p_window_opens_ch0_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_window_o) |-> (chan_idx_o == '0));
  p_window_closes_on_sweep_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_window_o) |-> $past(sweep_done_o));
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    rst |=> !(mux_step_o || adc_conv_o || smp_tick_o || tx_window_o));
endmodule

// File: tb/samp_timing_gen_test.sv
`timescale 1ns/1ps
module samp_timing_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mux_step_o, adc_conv_o, smp_tick_o, sweep_done_o, tx_window_o;
  logic [3:0] chan_idx_o;

  int checks = 0;
  int failures = 0;
  int n = 0; // rising edges seen with rst low since last reset

  always #5 clk = ~clk;

  samp_timing_gen uut (
    .clk(clk), .rst(rst),
    .mux_step_o(mux_step_o), .adc_conv_o(adc_conv_o), .smp_tick_o(smp_tick_o),
    .chan_idx_o(chan_idx_o), .sweep_done_o(sweep_done_o), .tx_window_o(tx_window_o)
  );

  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  // expected {mux, adc, smp, sweep, tx, chan} from the requirement timeline
  function automatic logic [8:0] expect_now(input int edges);
    int t, slot, period, ch, fr;
    if (edges == 0) return 9'd0;
    t      = edges - 1;
    slot   = t % 4;
    period = t / 4;
    ch     = period % 16;
    fr     = (period / 16) % 200;
    return {slot == 0, slot == 1, slot == 3, (slot == 3) && (ch == 15),
            fr == 199, 4'(ch)};
  endfunction

  task automatic check_now(input string req);
    logic [8:0] got, exp;
    got = {mux_step_o, adc_conv_o, smp_tick_o, sweep_done_o, tx_window_o, chan_idx_o};
    exp = expect_now(n);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s at edge %0d: got mux,adc,smp,sweep,tx,chan=%b exp %b",
               req, n, got, exp);
    end
  endtask

  task automatic check_value(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic run_check(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_now(req);
    end
  endtask

  task automatic skip_to(input int edges);
    while (n < edges) @(negedge clk);
  endtask

  task automatic t_reset_state;
    rst = 1'b1;
    run_check(3, "R1");
    rst = 1'b0;
  endtask

  task automatic t_slot_order;
    // first period starts right after the release edge
    run_check(8, "R3");
    check_value("R2", int'(mux_step_o) + int'(adc_conv_o) + int'(smp_tick_o), expect_now(n) >> 6 == 0 ? 0 : 1);
  endtask

  task automatic t_channel_sweep;
    int ticks = 0, strobes = 0;
    for (int i = 0; i < 72; i++) begin
      @(negedge clk);
      check_now("R4");
      ticks   += int'(smp_tick_o);
      strobes += int'(sweep_done_o);
    end
    check_value("R5 strobes per 72 cycles", strobes, 1);
    check_value("R2 ticks per 72 cycles", ticks, 18);
  endtask

  task automatic t_window(input int open_edge);
    int hi = 0, ticks = 0, strobes = 0, first = -1, last_sweep_at = -1;
    skip_to(open_edge - 1);
    for (int i = 0; i < 66; i++) begin
      @(negedge clk);
      check_now("R6");
      if (tx_window_o) begin
        if (first < 0) first = n;
        hi++;
        ticks   += int'(smp_tick_o);
        strobes += int'(sweep_done_o);
        if (sweep_done_o) last_sweep_at = hi;
      end
    end
    check_value("R6 window open edge", first, open_edge);
    check_value("R6 window length", hi, 64);
    check_value("R7 ticks in window", ticks, 16);
    check_value("R7 strobes in window", strobes, 1);
    check_value("R7 strobe in last window cycle", last_sweep_at, 64);
  endtask

  task automatic t_mid_reset;
    skip_to(n + 37);
    @(negedge clk);
    rst = 1'b1;
    run_check(3, "R8");
    rst = 1'b0;
    run_check(70, "R8");
  endtask

  initial begin : watchdog
    #1_000_000;
    failures++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state;
    t_slot_order;
    t_channel_sweep;
    t_window(12737);
    t_window(12737 + 12800);
    t_mid_reset;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule